// File: doc/BRIEF.md
# Doorbell Interrupt Write Translator

This block sits behind the host-facing window of a bridge that links two hosts. The first part of that window is a doorbell area, and the memory window begins at a programmable offset after it. When a host writes into the doorbell area, the block turns that write into an outbound message-signalled interrupt write to the peer host.

The write's offset selects the doorbell. The doorbell index is the offset divided by the entry size, and the entry size is a power of two given as a shift amount. Each index has its own slot in an address/data table that is filled in when the doorbells are configured. A hit produces exactly one outbound write of the slot's 32-bit data word to the slot's 64-bit address. Several slots may hold the same address, in which case only their data words tell the interrupts apart. This lets single-address and per-vector interrupt schemes work through the same path.

The outbound side uses a valid/ready handshake behind a one-entry holding register. Writes that cannot ring a doorbell are swallowed and raise a sticky error flag. These are writes made before configuration, or writes whose index is at or above the active doorbell count.

Top module: `dbx_irq_xlat`

## Requirements
- R1: After reset, `ob_valid` is 0, `err_flag` is 0 and `wr_ready` is 1.
- R2: A write accepted at offset `ofs` below `mw_base` has doorbell index `ofs >> entry_shift`, rounded down. It rings that doorbell when `cfg_done` is 1 and the index is below both `active_cnt` and `NDB`. The cycle after acceptance, `ob_valid` is 1 with `ob_addr` = `tbl_addr[64*i +: 64]` and `ob_data` = `tbl_data[32*i +: 32]`, both sampled at acceptance. Slots that share one address still deliver their own data words.
- R3: The value on `wr_data` has no effect on the outbound address, the outbound data or the error flag.
- R4: A write in the doorbell area whose index is at or above `active_cnt` or at or above `NDB` is accepted but produces no outbound write, and it sets `err_flag` one cycle later.
- R5: A write in the doorbell area while `cfg_done` is 0 is accepted but produces no outbound write, and it sets `err_flag`.
- R6: A write at an offset at or above `mw_base` belongs to the memory window. It is accepted, produces no outbound write and leaves `err_flag` unchanged.
- R7: While `ob_valid` is 1 and `ob_ready` is 0, `wr_ready` is 0 and `ob_addr` and `ob_data` hold steady. When `ob_ready` returns, the pending write drains and a waiting write is taken in the same cycle.
- R8: Once set, `err_flag` stays at 1 until reset, whatever traffic follows.
- R9: Each hit gives exactly one outbound transfer: after the handshake with no new hit, `ob_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Doorbells have been configured |
| active_cnt | input | CNT_W | Number of active doorbells |
| entry_shift | input | SHIFT_W | log2 of the doorbell entry size in bytes |
| mw_base | input | OFS_W | Offset where the memory window starts |
| tbl_addr | input | NDB*64 | Per-slot interrupt address, slot i at bits 64*i |
| tbl_data | input | NDB*32 | Per-slot interrupt data, slot i at bits 32*i |
| wr_valid | input | 1 | Window write request |
| wr_ready | output | 1 | Window write accepted this cycle when high |
| wr_offset | input | OFS_W | Byte offset of the write in the window |
| wr_data | input | 32 | Write payload (not used) |
| ob_valid | output | 1 | Outbound interrupt write pending |
| ob_ready | input | 1 | Outbound side takes the write |
| ob_addr | output | 64 | Outbound write address |
| ob_data | output | 32 | Outbound write data |
| err_flag | output | 1 | Sticky flag for a dropped doorbell write |

## Verification
The checker watches on every cycle that a stalled outbound write keeps its address and data, that every hit raises `ob_valid` on the next cycle, and that a completed handshake with no new hit empties the register. It also checks that every dropped write sets the flag, that the flag never clears, and that memory-window writes leave the output idle. Only the bench scenarios can show that the correct table slot is chosen for each offset and entry size. The same holds for rounding offsets down inside an entry, slots that share one address, payload independence, and the exact order in which a stalled write drains while the next one is taken.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  localparam int OB_ADDR_W = 64;
  localparam int OB_DATA_W = 32;

  typedef enum logic [1:0] {
    DB_PASS = 2'd0,
    DB_RING = 2'd1,
    DB_DROP = 2'd2
  } db_kind_e;

  typedef struct packed {
    logic [OB_ADDR_W-1:0] addr;
    logic [OB_DATA_W-1:0] data;
  } ob_beat_t;
endpackage

// File: rtl/dbx_decode.sv
module dbx_decode
  import dbx_pkg::*;
#(
  parameter int NDB     = 32,
  parameter int OFS_W   = 16,
  parameter int SHIFT_W = 4,
  localparam int CNT_W  = $clog2(NDB + 1),
  localparam int IDX_W  = (NDB > 1) ? $clog2(NDB) : 1
) (
  input  logic [OFS_W-1:0]   offset,
  input  logic [SHIFT_W-1:0] entry_shift,
  input  logic [OFS_W-1:0]   mw_base,
  input  logic [CNT_W-1:0]   active_cnt,
  input  logic               cfg_done,
  output db_kind_e           kind,
  output logic [IDX_W-1:0]   idx
);
  localparam logic [OFS_W-1:0] NDB_OFS = OFS_W'(NDB);

  function automatic logic [OFS_W-1:0] slot_of(input logic [OFS_W-1:0] ofs,
                                               input logic [SHIFT_W-1:0] sh);
    return ofs >> sh;
  endfunction

  function automatic db_kind_e classify(input logic [OFS_W-1:0] ofs,
                                        input logic [OFS_W-1:0] slot,
                                        input logic [OFS_W-1:0] base,
                                        input logic [CNT_W-1:0] cnt,
                                        input logic             ready_cfg);
    if (ofs >= base) return DB_PASS;
    if (!ready_cfg) return DB_DROP;
    if (slot >= {{(OFS_W-CNT_W){1'b0}}, cnt}) return DB_DROP;
    if (slot >= NDB_OFS) return DB_DROP;
    return DB_RING;
  endfunction

  logic [OFS_W-1:0] slot;

  always_comb begin
    slot = slot_of(offset, entry_shift);
    kind = classify(offset, slot, mw_base, active_cnt, cfg_done);
    idx  = slot[IDX_W-1:0];
  end
endmodule

// File: rtl/dbx_slot_mux.sv
module dbx_slot_mux
  import dbx_pkg::*;
#(
  parameter int NDB    = 32,
  localparam int IDX_W = (NDB > 1) ? $clog2(NDB) : 1
) (
  input  logic [NDB*OB_ADDR_W-1:0] tbl_addr,
  input  logic [NDB*OB_DATA_W-1:0] tbl_data,
  input  logic [IDX_W-1:0]         idx,
  output ob_beat_t                 beat
);
  ob_beat_t slots [NDB];

  for (genvar g = 0; g < NDB; g++) begin : g_slot
    assign slots[g].addr = tbl_addr[g*OB_ADDR_W +: OB_ADDR_W];
    assign slots[g].data = tbl_data[g*OB_DATA_W +: OB_DATA_W];
  end

  always_comb begin
    beat = slots[idx];
  end
endmodule

// File: rtl/dbx_hold.sv
module dbx_hold
  import dbx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_fire,
  input  ob_beat_t in_beat,
  input  logic     out_ready,
  output logic     can_take,
  output logic     out_valid,
  output ob_beat_t out_beat
);
  always_comb begin
    can_take = !out_valid || out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beat  <= '0;
    end else begin
      if (in_fire) begin
        out_valid <= 1'b1;
        out_beat  <= in_beat;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbx_irq_xlat.sv
module dbx_irq_xlat
  import dbx_pkg::*;
#(
  parameter int NDB      = 32,
  parameter int OFS_W    = 16,
  parameter int SHIFT_W  = 4,
  localparam int CNT_W   = $clog2(NDB + 1),
  localparam int IDX_W   = (NDB > 1) ? $clog2(NDB) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_done,
  input  logic [CNT_W-1:0]         active_cnt,
  input  logic [SHIFT_W-1:0]       entry_shift,
  input  logic [OFS_W-1:0]         mw_base,
  input  logic [NDB*OB_ADDR_W-1:0] tbl_addr,
  input  logic [NDB*OB_DATA_W-1:0] tbl_data,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [OFS_W-1:0]         wr_offset,
  input  logic [31:0]              wr_data,
  output logic                     ob_valid,
  input  logic                     ob_ready,
  output logic [OB_ADDR_W-1:0]     ob_addr,
  output logic [OB_DATA_W-1:0]     ob_data,
  output logic                     err_flag
);
  db_kind_e         kind;
  logic [IDX_W-1:0] idx;
  ob_beat_t         sel_beat;
  ob_beat_t         out_beat;
  logic             can_take;
  logic             wr_fire;
  logic             ring_ev;
  logic             drop_ev;
  logic             pass_ev;
  logic             unused_payload;

  assign unused_payload = ^wr_data;

  dbx_decode #(.NDB(NDB), .OFS_W(OFS_W), .SHIFT_W(SHIFT_W)) u_decode (
    .offset      (wr_offset),
    .entry_shift (entry_shift),
    .mw_base     (mw_base),
    .active_cnt  (active_cnt),
    .cfg_done    (cfg_done),
    .kind        (kind),
    .idx         (idx)
  );

  dbx_slot_mux #(.NDB(NDB)) u_mux (
    .tbl_addr (tbl_addr),
    .tbl_data (tbl_data),
    .idx      (idx),
    .beat     (sel_beat)
  );

  assign wr_ready = can_take;
  assign wr_fire  = wr_valid && can_take;
  assign ring_ev  = wr_fire && (kind == DB_RING);
  assign drop_ev  = wr_fire && (kind == DB_DROP);
  assign pass_ev  = wr_fire && (kind == DB_PASS);

  dbx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (ring_ev),
    .in_beat   (sel_beat),
    .out_ready (ob_ready),
    .can_take  (can_take),
    .out_valid (ob_valid),
    .out_beat  (out_beat)
  );

  assign ob_addr = out_beat.addr;
  assign ob_data = out_beat.data;

  always_ff @(posedge clk) begin
    if (!rst_n) err_flag <= 1'b0;
    else if (drop_ev) err_flag <= 1'b1;
  end
endmodule

// File: rtl/dbx_irq_xlat_chk.sv
module dbx_irq_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ob_valid,
  input logic        ob_ready,
  input logic [63:0] ob_addr,
  input logic [31:0] ob_data,
  input logic        err_flag,
  input logic        ring_ev,
  input logic        drop_ev,
  input logic        pass_ev
);
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && !ob_ready |=> ob_valid && $stable(ob_addr) && $stable(ob_data));

  assert_ring_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ring_ev |=> ob_valid);

  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> err_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_single_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && ob_ready && !ring_ev |=> !ob_valid);

  assert_window_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_ev && !ob_valid |=> !ob_valid && $stable(err_flag));
endmodule

bind dbx_irq_xlat dbx_irq_xlat_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ob_valid (ob_valid),
  .ob_ready (ob_ready),
  .ob_addr  (ob_addr),
  .ob_data  (ob_data),
  .err_flag (err_flag),
  .ring_ev  (ring_ev),
  .drop_ev  (drop_ev),
  .pass_ev  (pass_ev)
);

// File: tb/dbx_irq_xlat_bench.sv
module dbx_irq_xlat_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDB = 32;
  localparam int OFS_W = 16;
  localparam int SHIFT_W = 4;
  localparam int CNT_W = $clog2(NDB + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_done = 0;
  logic [CNT_W-1:0] active_cnt = '0;
  logic [SHIFT_W-1:0] entry_shift = 4'd3;
  logic [OFS_W-1:0] mw_base = 16'h8000;
  logic [NDB*64-1:0] tbl_addr;
  logic [NDB*32-1:0] tbl_data;
  logic wr_valid = 0;
  logic wr_ready;
  logic [OFS_W-1:0] wr_offset = '0;
  logic [31:0] wr_data = '0;
  logic ob_valid;
  logic ob_ready = 0;
  logic [63:0] ob_addr;
  logic [31:0] ob_data;
  logic err_flag;

  logic [63:0] exp_addr [NDB];
  logic [31:0] exp_data [NDB];
  int checks = 0;
  int errors = 0;
  bit exp_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbx_irq_xlat #(.NDB(NDB), .OFS_W(OFS_W), .SHIFT_W(SHIFT_W)) u_dbx_irq_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .active_cnt(active_cnt),
    .entry_shift(entry_shift), .mw_base(mw_base), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_offset(wr_offset), .wr_data(wr_data), .ob_valid(ob_valid),
    .ob_ready(ob_ready), .ob_addr(ob_addr), .ob_data(ob_data),
    .err_flag(err_flag)
  );

  // 0: memory window, 1: rings a doorbell, 2: dropped
  function automatic int kind_of(input int ofs, input int sh, input int cnt, input bit cfg);
    int slot;
    if (ofs >= int'(mw_base)) return 0;
    slot = ofs / (1 << sh);
    if (!cfg || slot >= cnt || slot >= NDB) return 2;
    return 1;
  endfunction

  function automatic int slot_for(input int ofs, input int sh);
    return ofs / (1 << sh);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    wr_valid = 0;
    ob_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_err = 0;
  endtask

  // returns at the negedge after the write was accepted
  task automatic send(input logic [OFS_W-1:0] ofs, input logic [31:0] pay);
    @(negedge clk);
    wr_valid = 1;
    wr_offset = ofs;
    wr_data = pay;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic run_one(input logic [OFS_W-1:0] ofs, input logic [31:0] pay, input string req);
    int k;
    int s;
    k = kind_of(int'(ofs), int'(entry_shift), int'(active_cnt), cfg_done);
    s = slot_for(int'(ofs), int'(entry_shift));
    ob_ready = 0;
    send(ofs, pay);
    if (k == 1) begin
      check(ob_valid == 1'b1, {req, " R2 valid"}, 64'(ob_valid), 64'd1);
      check(ob_addr == exp_addr[s], {req, " R2 addr"}, ob_addr, exp_addr[s]);
      check(ob_data == exp_data[s], {req, " R2 data"}, 64'(ob_data), 64'(exp_data[s]));
      ob_ready = 1;
      @(negedge clk);
      check(ob_valid == 1'b0, {req, " R9 single"}, 64'(ob_valid), 64'd0);
      ob_ready = 0;
    end else begin
      if (k == 2) exp_err = 1;
      check(ob_valid == 1'b0, {req, " R4/R5/R6 no outbound"}, 64'(ob_valid), 64'd0);
    end
    check(err_flag == exp_err, {req, " R8 flag"}, 64'(err_flag), 64'(exp_err));
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NDB; i++) begin
      exp_addr[i] = (i % 4 == 0) ? 64'h0000_00FE_E000_1000 : {$urandom, $urandom};
      exp_data[i] = $urandom;
      tbl_addr[i*64 +: 64] = exp_addr[i];
      tbl_data[i*32 +: 32] = exp_data[i];
    end

    do_reset();
    // R1
    check(ob_valid == 1'b0, "R1 ob_valid", 64'(ob_valid), 64'd0);
    check(err_flag == 1'b0, "R1 err_flag", 64'(err_flag), 64'd0);
    check(wr_ready == 1'b1, "R1 wr_ready", 64'(wr_ready), 64'd1);

    // R5: before configuration
    active_cnt = 6'd4; entry_shift = 4'd3; cfg_done = 0;
    run_one(16'd8, 32'h1, "R5 unconfigured");

    // R2/R3/R4/R8 directed
    do_reset();
    cfg_done = 1;
    run_one(16'd0, 32'hAAAA_AAAA, "R2 slot0");
    run_one(16'd24, 32'h0, "R2 slot3");
    run_one(16'd31, 32'hFFFF_FFFF, "R3 floor and payload");
    run_one(16'd32, 32'h5, "R4 beyond count");
    run_one(16'd8, 32'h6, "R8 still set after hit");

    // R6: memory window write
    do_reset();
    run_one(16'h8004, 32'h7, "R6 window");
    active_cnt = 6'd33; entry_shift = 4'd2;
    run_one(16'd128, 32'h8, "R4 beyond NDB");

    // R7 backpressure
    do_reset();
    active_cnt = 6'd8; entry_shift = 4'd2;
    ob_ready = 0;
    send(16'd4, 32'h9);
    @(negedge clk);
    wr_valid = 1; wr_offset = 16'd8; wr_data = 32'hA;
    for (int c = 0; c < 3; c++) begin
      check(wr_ready == 1'b0, "R7 stall ready", 64'(wr_ready), 64'd0);
      check(ob_addr == exp_addr[1] && ob_valid, "R7 stable addr", ob_addr, exp_addr[1]);
      @(negedge clk);
    end
    ob_ready = 1;
    @(negedge clk);
    wr_valid = 0;
    check(ob_valid && ob_data == exp_data[2], "R7 drain and take", 64'(ob_data), 64'(exp_data[2]));
    @(negedge clk);
    check(ob_valid == 1'b0, "R9 empty after drain", 64'(ob_valid), 64'd0);
    ob_ready = 0;

    // shared-address slots, R2
    active_cnt = 6'd32; entry_shift = 4'd2;
    run_one(16'd16, 32'h0, "R2 shared slot4");
    run_one(16'd32, 32'h0, "R2 shared slot8");

    // random mix
    for (int n = 0; n < 300; n++) begin
      entry_shift = SHIFT_W'(2 + ($urandom % 3));
      active_cnt = CNT_W'($urandom % 34);
      cfg_done = ($urandom % 8) != 0;
      run_one(OFS_W'($urandom % 16'h9000), $urandom, "rand R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule